// File: doc/BRIEF.md
# T1/E1 Transmit Line Encoder

This block turns a stream of transmit bits into a pair of pulse rails for a line driver. It takes bits from one of two sources, a primary source or a loopback source. Each source has a bit clock and a data pair. A bit is taken on the falling edge of the selected bit clock, which the block detects on its own fast system clock. The data pair can carry dual-rail bipolar data, where either rail high means a one. It can also carry single-rail NRZ data, with both rails tied together. In both cases the block reduces the bit to a mark or a space. It then generates the alternate mark inversion polarity itself.

When zero code suppression is on, long runs of zeros are replaced by code words that hold deliberate bipolar violations. In T1 mode an eight-zero run is replaced by the B8ZS word. In E1 mode a four-zero run is replaced by an HDB3 word. An alarm input forces every bit to a mark, so the line carries all ones at the rate of the selected bit clock.

An eight-slot look-ahead buffer lets a code word overwrite zeros that have already been accepted. As a result, every bit leaves exactly eight bit periods after it was taken, in either mode. This latency is exposed as the parameter `LATENCY_BITS`. The output side is a one-cycle `line_valid` strobe for each bit, with the rails held in between. The line cannot pause, so there is no ready signal and no back-pressure. A consumer must accept each strobe when it comes.

Top module: `tle_line_encoder`

## Requirements
- R1: Synchronous active-high reset clears the rails, the strobe, the buffer and the run counter. After reset the HDB3 parity is even, so a first four-zero run in E1 mode becomes B00V. The polarity state is set so that the first pulse after reset goes on the positive rail.
- R2: A bit is taken in the system clock cycle in which the selected bit clock is seen low after having been high. With `lb_sel` low the primary clock and pair are used. With `lb_sel` high the loopback clock and pair are used. The unselected clock and pair have no effect on the rails.
- R3: An input bit is a mark when either rail of the selected pair is high. Both rails high, as in tied NRZ input, counts as a single mark and not as two pulses.
- R4: For each bit taken, `line_valid` is high for exactly one cycle, one cycle after the bit is taken. At that strobe the rails show the symbol of the bit taken `LATENCY_BITS` (8) bits earlier. Before 8 bits have been taken, the rails show spaces. Between strobes the rails hold their value.
- R5: `line_pos` and `line_neg` are never high together. Ordinary marks alternate polarity relative to the previous pulse.
- R6: With `zcs_en` low, zeros pass as spaces with no substitution, whatever the run length.
- R7: With `zcs_en` high and `e1_mode` low, each run of eight zeros is sent as 000VB0VB. Here V has the same polarity as the previous pulse and B has the opposite polarity.
- R8: With `zcs_en` high and `e1_mode` high, each run of four zeros is replaced. It is sent as 000V when an odd number of pulses has gone out since the last violation, and as B00V when that number is even. The parity then restarts at even.
- R9: While `alarm_en` is high when a bit is taken, that bit is a mark regardless of the data pair. A held alarm therefore yields continuous AMI ones, with no substitution.
- R10: The zero-run count restarts after every substitution. A run of 16 zeros in T1 mode gives two B8ZS words, and a run of 8 zeros in E1 mode gives two HDB3 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_bclk | input | 1 | Primary bit clock; bits taken on its falling edge |
| pri_pos | input | 1 | Primary positive data rail |
| pri_neg | input | 1 | Primary negative data rail |
| lb_bclk | input | 1 | Loopback bit clock |
| lb_pos | input | 1 | Loopback positive data rail |
| lb_neg | input | 1 | Loopback negative data rail |
| lb_sel | input | 1 | High selects the loopback source |
| e1_mode | input | 1 | High: E1 rate, HDB3; low: T1 rate, B8ZS |
| zcs_en | input | 1 | Enables zero code suppression |
| alarm_en | input | 1 | Forces all-ones transmission |
| line_pos | output | 1 | Positive pulse rail |
| line_neg | output | 1 | Negative pulse rail |
| line_valid | output | 1 | One-cycle strobe per output bit |

## Verification
A polarity register that is wrong shows up on the very next strobe that carries a mark or a B. That pulse lands on the wrong rail, or the pulses stop alternating. A stale HDB3 parity bit stays hidden until the next four-zero run. That run then leaves the block eight bit periods later as the wrong one of 000V and B00V. A zero-run counter that is wrong, or that fails to restart, shows as a missing, shifted or extra code word. This is caught by comparing each output bit with a reference encoding of the whole input sequence. A buffer or latency error misaligns every later bit of that comparison.

// File: rtl/tle_pkg.sv
package tle_pkg;
  // Symbol held in each look-ahead slot; the output stage assigns polarity.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_BIP  = 2'd2,
    SYM_VIOL = 2'd3
  } sym_e;

  localparam int B8ZS_RUN  = 8;
  localparam int HDB3_RUN  = 4;
  localparam int MIN_DEPTH = 8;
endpackage

// File: rtl/tle_src_sel.sv
module tle_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic pri_bclk,
  input  logic pri_pos,
  input  logic pri_neg,
  input  logic lb_bclk,
  input  logic lb_pos,
  input  logic lb_neg,
  input  logic lb_sel,
  input  logic alarm_en,
  output logic bit_stb,
  output logic bit_mark
);
  logic pri_q, lb_q;
  logic pri_fall, lb_fall;
  logic pri_mark, lb_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= 1'b0;
      lb_q  <= 1'b0;
    end else begin
      pri_q <= pri_bclk;
      lb_q  <= lb_bclk;
    end
  end

  assign pri_fall = pri_q & ~pri_bclk;
  assign lb_fall  = lb_q & ~lb_bclk;
  // Either rail high is one mark; tied NRZ rails collapse to one mark.
  assign pri_mark = pri_pos | pri_neg;
  assign lb_mark  = lb_pos | lb_neg;

  assign bit_stb  = lb_sel ? lb_fall : pri_fall;
  assign bit_mark = alarm_en | (lb_sel ? lb_mark : pri_mark);
endmodule

// File: rtl/tle_zcs_buf.sv
module tle_zcs_buf
  import tle_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic bit_mark,
  input  logic e1_mode,
  input  logic zcs_en,
  output sym_e leave_sym
);
  localparam int RUN_W = $clog2(DEPTH + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(DEPTH);

  sym_e             slot_q [DEPTH];
  sym_e             slot_d [DEPTH];
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] lim_m1;
  logic             par_q;
  logic             sub_fire;

  assign lim_m1   = e1_mode ? RUN_W'(HDB3_RUN - 1) : RUN_W'(B8ZS_RUN - 1);
  assign sub_fire = zcs_en && !bit_mark && (run_q >= lim_m1);

  // Next buffer: shift by one slot, then overlay a code word on the
  // newest slots when a full zero run is complete.
  always_comb begin
    slot_d[0] = bit_mark ? SYM_MARK : SYM_ZERO;
    for (int i = 1; i < DEPTH; i++) begin
      slot_d[i] = slot_q[i-1];
    end
    if (sub_fire) begin
      if (!e1_mode) begin
        slot_d[4] = SYM_VIOL;
        slot_d[3] = SYM_BIP;
        slot_d[1] = SYM_VIOL;
        slot_d[0] = SYM_BIP;
      end else begin
        slot_d[0] = SYM_VIOL;
        if (!par_q) begin
          slot_d[3] = SYM_BIP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot_q[i] <= SYM_ZERO;
      end
    end else if (bit_stb) begin
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      par_q <= 1'b0;
    end else if (bit_stb) begin
      if (sub_fire) begin
        run_q <= '0;
        par_q <= 1'b0;
      end else if (bit_mark) begin
        run_q <= '0;
        par_q <= ~par_q;
      end else if (run_q < RUN_SAT) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign leave_sym = slot_q[DEPTH-1];
endmodule

// File: rtl/tle_ami_out.sv
module tle_ami_out
  import tle_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  sym_e leave_sym,
  output logic line_pos,
  output logic line_neg,
  output logic line_valid
);
  logic last_neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos   <= 1'b0;
      line_neg   <= 1'b0;
      line_valid <= 1'b0;
      last_neg_q <= 1'b1;
    end else begin
      line_valid <= bit_stb;
      if (bit_stb) begin
        unique case (leave_sym)
          SYM_ZERO: begin
            line_pos <= 1'b0;
            line_neg <= 1'b0;
          end
          SYM_MARK, SYM_BIP: begin
            line_pos   <= last_neg_q;
            line_neg   <= ~last_neg_q;
            last_neg_q <= ~last_neg_q;
          end
          SYM_VIOL: begin
            line_pos <= ~last_neg_q;
            line_neg <= last_neg_q;
          end
          default: begin
            line_pos <= 1'b0;
            line_neg <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tle_line_encoder.sv
module tle_line_encoder
  import tle_pkg::*;
#(
  parameter int LOOK_DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pri_bclk,
  input  logic pri_pos,
  input  logic pri_neg,
  input  logic lb_bclk,
  input  logic lb_pos,
  input  logic lb_neg,
  input  logic lb_sel,
  input  logic e1_mode,
  input  logic zcs_en,
  input  logic alarm_en,
  output logic line_pos,
  output logic line_neg,
  output logic line_valid
);
  localparam int DEPTH        = (LOOK_DEPTH < MIN_DEPTH) ? MIN_DEPTH : LOOK_DEPTH;
  localparam int LATENCY_BITS = DEPTH;

  logic bit_stb;
  logic bit_mark;
  sym_e leave_sym;

  tle_src_sel u_src (
    .clk      (clk),
    .rst      (rst),
    .pri_bclk (pri_bclk),
    .pri_pos  (pri_pos),
    .pri_neg  (pri_neg),
    .lb_bclk  (lb_bclk),
    .lb_pos   (lb_pos),
    .lb_neg   (lb_neg),
    .lb_sel   (lb_sel),
    .alarm_en (alarm_en),
    .bit_stb  (bit_stb),
    .bit_mark (bit_mark)
  );

  tle_zcs_buf #(.DEPTH(DEPTH)) u_zcs (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .bit_mark  (bit_mark),
    .e1_mode   (e1_mode),
    .zcs_en    (zcs_en),
    .leave_sym (leave_sym)
  );

  tle_ami_out u_ami (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .leave_sym  (leave_sym),
    .line_pos   (line_pos),
    .line_neg   (line_neg),
    .line_valid (line_valid)
  );
endmodule

// File: rtl/tle_line_encoder_chk.sv
module tle_line_encoder_chk
  import tle_pkg::*;
#(
  parameter int LATENCY_BITS = 8
) (
  input logic clk,
  input logic rst,
  input logic bit_stb,
  input sym_e leave_sym,
  input logic alarm_en,
  input logic line_pos,
  input logic line_neg,
  input logic line_valid
);
  localparam int CW = $clog2(LATENCY_BITS + 2);
  localparam logic [CW-1:0] AL_FULL = CW'(LATENCY_BITS + 1);

  sym_e          sent_sym_q;
  logic          chk_last_neg_q;
  logic [CW-1:0] al_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_sym_q     <= SYM_ZERO;
      chk_last_neg_q <= 1'b1;
      al_run_q       <= '0;
    end else begin
      if (bit_stb) begin
        sent_sym_q <= leave_sym;
        if (!alarm_en) al_run_q <= '0;
        else if (al_run_q < AL_FULL) al_run_q <= al_run_q + 1'b1;
      end
      if (line_valid && (line_pos || line_neg)) chk_last_neg_q <= line_neg;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!line_valid && !line_pos && !line_neg)); // R1

  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(line_pos && line_neg)); // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_valid |=> !line_valid); // R4

  AST_RAILS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> ($stable(line_pos) && $stable(line_neg))); // R4

  AST_AMI_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (line_valid && (sent_sym_q == SYM_MARK || sent_sym_q == SYM_BIP))
      |-> (line_pos == chk_last_neg_q && line_neg == !chk_last_neg_q)); // R5

  AST_VIOL_SAME: assert property (@(posedge clk) disable iff (rst)
    (line_valid && sent_sym_q == SYM_VIOL)
      |-> (line_neg == chk_last_neg_q && line_pos == !chk_last_neg_q)); // R7

  AST_ALARM_ONES: assert property (@(posedge clk) disable iff (rst)
    (line_valid && al_run_q >= AL_FULL) |-> (line_pos || line_neg)); // R9
endmodule

bind tle_line_encoder tle_line_encoder_chk #(.LATENCY_BITS(LATENCY_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_stb    (bit_stb),
  .leave_sym  (leave_sym),
  .alarm_en   (alarm_en),
  .line_pos   (line_pos),
  .line_neg   (line_neg),
  .line_valid (line_valid)
);

// File: tb/sim_tle_line_encoder.sv
module sim_tle_line_encoder;
  localparam int LAT  = 8;
  localparam int MAXB = 512;
  localparam int C_Z = 0, C_M = 1, C_B = 2, C_V = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic pri_bclk = 1'b0, pri_pos = 1'b0, pri_neg = 1'b0;
  logic lb_bclk = 1'b0, lb_pos = 1'b0, lb_neg = 1'b0;
  logic lb_sel = 1'b0, e1_mode = 1'b0, zcs_en = 1'b0, alarm_en = 1'b0;
  logic line_pos, line_neg, line_valid;

  tle_line_encoder u0 (
    .clk(clk), .rst(rst),
    .pri_bclk(pri_bclk), .pri_pos(pri_pos), .pri_neg(pri_neg),
    .lb_bclk(lb_bclk), .lb_pos(lb_pos), .lb_neg(lb_neg),
    .lb_sel(lb_sel), .e1_mode(e1_mode), .zcs_en(zcs_en), .alarm_en(alarm_en),
    .line_pos(line_pos), .line_neg(line_neg), .line_valid(line_valid)
  );

  int n_chk = 0, n_fail = 0;
  bit st_p [MAXB], st_n [MAXB], st_a [MAXB];
  int code [MAXB];
  bit gp [MAXB], gn [MAXB];
  bit rp [MAXB], rn [MAXB];
  int rx_n = 0;

  always @(negedge clk) begin
    if (!rst && line_valid && rx_n < MAXB) begin
      rp[rx_n] = line_pos;
      rn[rx_n] = line_neg;
      rx_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; pri_bclk = 1'b0; lb_bclk = 1'b0; alarm_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_n = 0;
    check(!line_pos && !line_neg && !line_valid, "R1", "rails/strobe in reset",
          {line_pos, line_neg, line_valid}, 0);
    rst = 1'b0;
  endtask

  task automatic send_bit(input bit p, input bit n, input bit al);
    bit jp = 1'($urandom_range(1));
    bit jn = 1'($urandom_range(1));
    alarm_en = al;
    if (lb_sel) begin
      lb_pos = p; lb_neg = n; pri_pos = jp; pri_neg = jn;
    end else begin
      pri_pos = p; pri_neg = n; lb_pos = jp; lb_neg = jn;
    end
    pri_bclk = 1'b1; lb_bclk = 1'b1;
    repeat (3) @(negedge clk);
    pri_bclk = 1'b0; lb_bclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Reference encoder written from R3, R5..R10.
  task automatic build_gold(input int n, input bit e1, input bit zcs);
    int run = 0;
    bit par = 1'b0;
    bit lneg = 1'b1;
    int lim = e1 ? 4 : 8;
    for (int k = 0; k < n; k++) begin
      bit m = st_a[k] | st_p[k] | st_n[k];
      code[k] = m ? C_M : C_Z;
      if (m) begin
        run = 0; par = ~par;
      end else begin
        run++;
        if (zcs && run == lim) begin
          if (!e1) begin
            code[k-4] = C_V; code[k-3] = C_B; code[k-1] = C_V; code[k] = C_B;
          end else begin
            code[k] = C_V;
            if (!par) code[k-3] = C_B;
          end
          run = 0; par = 1'b0;
        end
      end
    end
    for (int k = 0; k < n; k++) begin
      if (code[k] == C_Z) begin
        gp[k] = 1'b0; gn[k] = 1'b0;
      end else if (code[k] == C_V) begin
        gp[k] = ~lneg; gn[k] = lneg;
      end else begin
        gp[k] = lneg; gn[k] = ~lneg; lneg = ~lneg;
      end
    end
  endtask

  task automatic fill_random(input int n, input int dens, input bit nrz);
    for (int k = 0; k < n; k++) begin
      bit m = ($urandom_range(99) < dens);
      st_a[k] = 1'b0;
      if (nrz) begin
        st_p[k] = m; st_n[k] = m;
      end else begin
        bit side = 1'($urandom_range(1));
        st_p[k] = m & side; st_n[k] = m & ~side;
      end
    end
  endtask

  // Leading four zeros, then marks separated by runs of chosen lengths.
  task automatic fill_directed(output int n);
    int lens [10] = '{3, 4, 5, 7, 8, 9, 12, 16, 17, 24};
    int k = 0;
    for (int i = 0; i < 4; i++) begin st_p[k] = 0; st_n[k] = 0; st_a[k] = 0; k++; end
    for (int r = 0; r < 10; r++) begin
      st_p[k] = r[0]; st_n[k] = ~r[0]; st_a[k] = 0; k++;
      for (int z = 0; z < lens[r]; z++) begin st_p[k] = 0; st_n[k] = 0; st_a[k] = 0; k++; end
    end
    for (int i = 0; i < 12; i++) begin st_p[k] = 0; st_n[k] = 1; st_a[k] = 0; k++; end
    n = k;
  endtask

  task automatic run_seg(input string req, input int n, input bit lb,
                         input bit e1, input bit zcs);
    lb_sel = lb; e1_mode = e1; zcs_en = zcs;
    do_reset();
    for (int k = 0; k < n; k++) send_bit(st_p[k], st_n[k], st_a[k]);
    repeat (4) @(negedge clk);
    build_gold(n, e1, zcs);
    check(rx_n == n, "R4", "strobe count", rx_n, n);
    for (int k = 0; k < n && k < rx_n; k++) begin
      bit ep = (k < LAT) ? 1'b0 : gp[k-LAT];
      bit en = (k < LAT) ? 1'b0 : gn[k-LAT];
      check(rp[k] == ep && rn[k] == en, req, $sformatf("bit %0d rails", k),
            {rp[k], rn[k]}, {ep, en});
      check(!(rp[k] && rn[k]), "R5", $sformatf("bit %0d both rails", k), 3, 0);
    end
  endtask

  task automatic run_all();
    int n;
    void'($urandom(32'h5EED_0A11));
    fill_random(200, 50, 1'b0); run_seg("R6", 200, 1'b0, 1'b0, 1'b0);
    fill_random(200, 12, 1'b1); run_seg("R3", 200, 1'b0, 1'b0, 1'b0);
    fill_random(300, 10, 1'b0); run_seg("R7", 300, 1'b0, 1'b0, 1'b1);
    fill_random(300, 25, 1'b0); run_seg("R8", 300, 1'b0, 1'b1, 1'b1);
    fill_directed(n);           run_seg("R10", n, 1'b0, 1'b0, 1'b1);
    check(rp[LAT+4] == 1'b1 && rn[LAT+4] == 1'b0, "R1", "first pulse positive",
          {rp[LAT+4], rn[LAT+4]}, 2);
    fill_directed(n);           run_seg("R10", n, 1'b0, 1'b1, 1'b1);
    check(rp[LAT] == 1'b1 && rp[LAT+3] == 1'b1 && !rp[LAT+1] && !rn[LAT+1],
          "R1", "first HDB3 word B00V", {rp[LAT], rp[LAT+3]}, 3);
    fill_random(250, 20, 1'b1); run_seg("R2", 250, 1'b1, 1'b1, 1'b1);
    fill_random(250, 30, 1'b0); run_seg("R2", 250, 1'b1, 1'b0, 1'b0);
    fill_random(200, 5, 1'b0);
    for (int k = 40; k < 120; k++) st_a[k] = 1'b1;
    run_seg("R9", 200, 1'b0, 1'b1, 1'b1);
    for (int k = 50 + LAT; k < 120; k++)
      check(rp[k] || rn[k], "R9", $sformatf("alarm bit %0d is a pulse", k),
            {rp[k], rn[k]}, 1);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule